// File: doc/BRIEF.md
# Sized Integer ALU with Flags

This block is the integer arithmetic and logic stage of a microcoded datapath. Each cycle it takes one micro-operation: an operation code, an operand width of 1, 2, 4 or 8 bytes, a first source, a second source, an 8-bit immediate with a select that picks which of the two feeds the second operand, a condition input, a mask naming which condition-code bits may be written, the current condition-code word and the present value of the destination register. It returns the new destination value and the new condition-code word through one output register, one cycle after the inputs.

The eight operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR and a conditional move. All results are cut to the operand width and then merged into the old destination value, so a byte or word operation leaves the upper part of the register in place. Flags are computed at the operand width and written only where the mask allows. Flag positions in the 16-bit condition word are: carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11.

Top module: `sized_alu`

## Requirements
- R1: Operation code 0 (add) produces src1 + op2; code 1 (add with carry) produces src1 + op2 + cc_i[0], each taken at the operand width.
- R2: Operation code 2 (subtract) produces src1 - op2; code 3 (subtract with borrow) produces src1 - op2 - cc_i[0], at the operand width.
- R3: Only condition bits set in flag_mask_i at the six flag positions (0, 2, 4, 6, 7, 11) are written; every other bit of cc_o equals the cc_i bit of the same cycle.
- R4: When use_imm_i is 1 the second operand is imm_i zero-extended to 64 bits and src2_i is ignored; when 0 it is src2_i.
- R5: Codes 4, 5 and 6 produce src1 AND, OR and XOR op2; for them carry, overflow and auxiliary carry are written as 0 where selected.
- R6: Code 7 (conditional move) writes op2 into the destination when cond_i is 1, and returns dest_old_i unchanged in all 64 bits when cond_i is 0.
- R7: Size code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. For 1 and 2 bytes the bits above the operand come from dest_old_i; for 4 bytes bits 63:32 are zero; for 8 bytes the whole result is written.
- R8: For add forms the carry flag is the carry out of the operand's top bit and the auxiliary flag the carry out of bit 3; for subtract forms both report a borrow (carry flag set when src1 < op2 + borrow-in, unsigned at the operand width; auxiliary flag likewise on the low 4 bits).
- R9: Zero flag is set when the operand-width result is zero, sign flag is the result's top bit at the operand width, parity flag is set when bits 7:0 of the result hold an even number of ones.
- R10: Overflow is set when the operation's true signed result at the operand width lies outside the signed range of that width.
- R11: The conditional move leaves cc_o equal to cc_i whatever the mask.
- R12: While rst_n is low dest_o and cc_o are zero; afterwards both reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand width code |
| use_imm_i | input | 1 | Select immediate as second operand |
| src1_i | input | 64 | First source |
| src2_i | input | 64 | Second source (register form) |
| imm_i | input | 8 | Immediate second operand |
| cond_i | input | 1 | Condition for the conditional move |
| flag_mask_i | input | 16 | Condition bits allowed to change |
| cc_i | input | 16 | Current condition-code word |
| dest_old_i | input | 64 | Present destination value |
| dest_o | output | 64 | Merged destination, registered |
| cc_o | output | 16 | Updated condition-code word, registered |

## Verification
The assertions watch, on every cycle, the properties that hold whatever the operands are: unmasked condition bits pass through, logic operations clear carry and overflow, a false conditional move holds the destination and flags, and the size merge keeps or clears the upper destination bits. The arithmetic values themselves, carry and borrow at each width, overflow at the signed range boundaries, parity, and the immediate path with a distracting src2_i, are shown only by the bench's sweep over all operations, widths, carry-in values and a table of boundary operands, where expected results come from wide integer arithmetic rather than from the adder structure.

// File: rtl/sized_alu_pkg.sv
package sized_alu_pkg;

  localparam int DATA_W = 64;

  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_AF = 4;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_OF = 11;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_CMOV = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } op_size_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flag_set_t;

  // Low bits that belong to the operand at a given width.
  function automatic logic [DATA_W-1:0] width_mask(op_size_e s);
    case (s)
      SZ_B:    return 64'h0000_0000_0000_00FF;
      SZ_W:    return 64'h0000_0000_0000_FFFF;
      SZ_D:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // Most significant bit of the operand at the given width.
  function automatic logic top_bit(logic [DATA_W-1:0] v, op_size_e s);
    case (s)
      SZ_B:    return v[7];
      SZ_W:    return v[15];
      SZ_D:    return v[31];
      default: return v[63];
    endcase
  endfunction

  // Carry that leaves the operand's top bit, recovered from sum ^ a ^ b.
  function automatic logic carry_out_at(logic [DATA_W:0] s, logic [DATA_W:0] a,
                                        logic [DATA_W:0] b, op_size_e sz);
    case (sz)
      SZ_B:    return s[8]  ^ a[8]  ^ b[8];
      SZ_W:    return s[16] ^ a[16] ^ b[16];
      SZ_D:    return s[32] ^ a[32] ^ b[32];
      default: return s[64] ^ a[64] ^ b[64];
    endcase
  endfunction

  // Place a sized result into the old destination value.
  function automatic logic [DATA_W-1:0] size_merge(logic [DATA_W-1:0] old_v,
                                                   logic [DATA_W-1:0] res,
                                                   op_size_e s);
    case (s)
      SZ_B:    return {old_v[63:8],  res[7:0]};
      SZ_W:    return {old_v[63:16], res[15:0]};
      SZ_D:    return {32'h0, res[31:0]};
      default: return res;
    endcase
  endfunction

  function automatic logic even_parity8(logic [7:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import sized_alu_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] op2_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{PAD_W{1'b0}}, imm_i};
  assign op2_o   = use_imm_i ? imm_ext : src2_i;
endmodule

// File: rtl/alu_compute.sv
module alu_compute
  import sized_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  op_size_e          size_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic              carry_in_flag_i,
  output logic [DATA_W-1:0] result_o,
  output flag_set_t         flags_o,
  output logic              is_logic_o,
  output logic              is_sub_o
);
  logic              is_arith;
  logic              cin;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   a_x, b_x, sum_x;
  logic [DATA_W-1:0] logic_res;
  logic              carry_top, carry_nib;
  logic              sign_a, sign_b, sign_r;

  assign is_arith   = (op_i == OP_ADD) || (op_i == OP_ADC) ||
                      (op_i == OP_SUB) || (op_i == OP_SBB);
  assign is_sub_o   = (op_i == OP_SUB) || (op_i == OP_SBB);
  assign is_logic_o = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);

  // Subtraction is an addition of the inverted operand; borrow-in inverts too.
  always_comb begin
    case (op_i)
      OP_ADC:  cin = carry_in_flag_i;
      OP_SUB:  cin = 1'b1;
      OP_SBB:  cin = ~carry_in_flag_i;
      default: cin = 1'b0;
    endcase
  end

  assign b_eff = is_sub_o ? ~op2_i : op2_i;
  assign a_x   = {1'b0, src1_i};
  assign b_x   = {1'b0, b_eff};
  assign sum_x = a_x + b_x + {{DATA_W{1'b0}}, cin};

  always_comb begin
    case (op_i)
      OP_AND:  logic_res = src1_i & op2_i;
      OP_OR:   logic_res = src1_i | op2_i;
      default: logic_res = src1_i ^ op2_i;
    endcase
  end

  assign result_o  = is_arith ? sum_x[DATA_W-1:0] : logic_res;

  assign carry_top = carry_out_at(sum_x, a_x, b_x, size_i);
  assign carry_nib = sum_x[4] ^ a_x[4] ^ b_x[4];
  assign sign_a    = top_bit(src1_i, size_i);
  assign sign_b    = top_bit(b_eff, size_i);
  assign sign_r    = top_bit(result_o, size_i);

  always_comb begin
    flags_o.zf = ((result_o & width_mask(size_i)) == '0);
    flags_o.sf = sign_r;
    flags_o.pf = even_parity8(result_o[7:0]);
    if (is_arith) begin
      flags_o.cf = is_sub_o ? ~carry_top : carry_top;
      flags_o.af = is_sub_o ? ~carry_nib : carry_nib;
      flags_o.of = (sign_a == sign_b) && (sign_r != sign_a);
    end else begin
      flags_o.cf = 1'b0;
      flags_o.af = 1'b0;
      flags_o.of = 1'b0;
    end
  end
endmodule

// File: rtl/alu_flag_update.sv
module alu_flag_update
  import sized_alu_pkg::*;
#(
  parameter int CC_W = 16
) (
  input  logic            hold_all_i,
  input  flag_set_t       flags_i,
  input  logic [CC_W-1:0] mask_i,
  input  logic [CC_W-1:0] cc_i,
  output logic [CC_W-1:0] cc_next_o
);
  localparam logic [CC_W-1:0] FLAG_BITS =
    CC_W'((1 << FL_CF) | (1 << FL_PF) | (1 << FL_AF) |
          (1 << FL_ZF) | (1 << FL_SF) | (1 << FL_OF));

  logic [CC_W-1:0] fresh;
  logic [CC_W-1:0] writable;

  always_comb begin
    fresh        = '0;
    fresh[FL_CF] = flags_i.cf;
    fresh[FL_PF] = flags_i.pf;
    fresh[FL_AF] = flags_i.af;
    fresh[FL_ZF] = flags_i.zf;
    fresh[FL_SF] = flags_i.sf;
    fresh[FL_OF] = flags_i.of;
  end

  assign writable  = hold_all_i ? '0 : (mask_i & FLAG_BITS);
  assign cc_next_o = (cc_i & ~writable) | (fresh & writable);
endmodule

// File: rtl/sized_alu.sv
module sized_alu
  import sized_alu_pkg::*;
#(
  parameter int IMM_W = 8,
  parameter int CC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              cond_i,
  input  logic [CC_W-1:0]   flag_mask_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic [DATA_W-1:0] dest_old_i,
  output logic [DATA_W-1:0] dest_o,
  output logic [CC_W-1:0]   cc_o
);
  alu_op_e           op;
  op_size_e          sz;
  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] core_res;
  flag_set_t         core_flags;
  logic              is_logic, is_sub, is_cmov;
  logic [DATA_W-1:0] dest_next;
  logic [CC_W-1:0]   cc_next;

  assign op      = alu_op_e'(op_i);
  assign sz      = op_size_e'(size_i);
  assign is_cmov = (op == OP_CMOV);

  alu_operand_sel #(.IMM_W(IMM_W)) u_opsel (
    .use_imm_i (use_imm_i),
    .src2_i    (src2_i),
    .imm_i     (imm_i),
    .op2_o     (op2)
  );

  alu_compute u_compute (
    .op_i            (op),
    .size_i          (sz),
    .src1_i          (src1_i),
    .op2_i           (op2),
    .carry_in_flag_i (cc_i[FL_CF]),
    .result_o        (core_res),
    .flags_o         (core_flags),
    .is_logic_o      (is_logic),
    .is_sub_o        (is_sub)
  );

  alu_flag_update #(.CC_W(CC_W)) u_flags (
    .hold_all_i (is_cmov),
    .flags_i    (core_flags),
    .mask_i     (flag_mask_i),
    .cc_i       (cc_i),
    .cc_next_o  (cc_next)
  );

  always_comb begin
    if (is_cmov)
      dest_next = cond_i ? size_merge(dest_old_i, op2, sz) : dest_old_i;
    else
      dest_next = size_merge(dest_old_i, core_res, sz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_o <= '0;
      cc_o   <= '0;
    end else begin
      dest_o <= dest_next;
      cc_o   <= cc_next;
    end
  end

  // ---------------- assertions ----------------
  p_unmasked_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cc_o & ~$past(flag_mask_i)) == ($past(cc_i) & ~$past(flag_mask_i))));

  p_logic_cf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_logic && flag_mask_i[FL_CF]) |=> (cc_o[FL_CF] == 1'b0));

  p_logic_of_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_logic && flag_mask_i[FL_OF]) |=> (cc_o[FL_OF] == 1'b0));

  p_cmov_false_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmov && !cond_i) |=> (dest_o == $past(dest_old_i)));

  p_dword_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_cmov && sz == SZ_D) |=> (dest_o[63:32] == 32'h0));

  p_byte_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sz == SZ_B) |=> (dest_o[63:8] == $past(dest_old_i[63:8])));

  p_cmov_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmov |=> (cc_o == $past(cc_i)));

  p_sub_plain_no_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB && is_sub && flag_mask_i[FL_CF] && src2_i == '0 && !use_imm_i)
      |=> (cc_o[FL_CF] == 1'b0));
endmodule

// File: tb/test_sized_alu.sv
module test_sized_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        use_imm_i = 1'b0;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic [7:0]  imm_i = '0;
  logic        cond_i = 1'b0;
  logic [15:0] flag_mask_i = '0;
  logic [15:0] cc_i = '0;
  logic [63:0] dest_old_i = '0;
  logic [63:0] dest_o;
  logic [15:0] cc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sized_alu i_sized_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
    .use_imm_i(use_imm_i), .src1_i(src1_i), .src2_i(src2_i), .imm_i(imm_i),
    .cond_i(cond_i), .flag_mask_i(flag_mask_i), .cc_i(cc_i),
    .dest_old_i(dest_old_i), .dest_o(dest_o), .cc_o(cc_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int k);
    case (k)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'hFFFF_FFFF_FFFF_FFFF;
      3:  return 64'h7F;
      4:  return 64'h80;
      5:  return 64'h7FFF;
      6:  return 64'h8000;
      7:  return 64'h7FFF_FFFF;
      8:  return 64'h8000_0000;
      9:  return 64'h7FFF_FFFF_FFFF_FFFF;
      10: return 64'h8000_0000_0000_0000;
      11: return 64'h0123_4567_89AB_CDEF;
      default: return 64'hF0F0_0F0F_1234_5678;
    endcase
  endfunction

  function automatic logic signed [67:0] sx(input logic [63:0] v, input int n);
    logic signed [67:0] r;
    r = $signed({4'b0, v});
    if (v[n-1]) r = r - (68'sd1 <<< n);
    return r;
  endfunction

  // Reference model built from the requirements with wide integer arithmetic.
  task automatic model(input int op, input int sz, input logic [63:0] a,
                       input logic [63:0] b, input logic cf_in, input logic cnd,
                       input logic [63:0] old_v, input logic [15:0] msk,
                       input logic [15:0] cc_in,
                       output logic [63:0] exp_d, output logic [15:0] exp_cc);
    int n;
    logic [63:0] m, r, full;
    logic [64:0] wide;
    logic c, af, of, zf, sf, pf;
    logic signed [67:0] sres, smax, smin;
    int ones;
    logic [15:0] fl, wr;
    n = 8 << sz;
    m = (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
    a = a & m;
    b = b & m;
    c = 1'b0; af = 1'b0; of = 1'b0;
    smax = (68'sd1 <<< (n - 1)) - 68'sd1;
    smin = -(68'sd1 <<< (n - 1));
    case (op)
      0, 1: begin
        logic ci;
        ci = (op == 1) ? cf_in : 1'b0;
        wide = {1'b0, a} + {1'b0, b} + {64'b0, ci};
        r = wide[63:0] & m;
        c = (wide > {1'b0, m});
        af = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, ci}) > 5'd15;
        sres = sx(a, n) + sx(b, n) + $signed({67'b0, ci});
        of = (sres > smax) || (sres < smin);
      end
      2, 3: begin
        logic bi;
        bi = (op == 3) ? cf_in : 1'b0;
        r = (a - b - {63'b0, bi}) & m;
        c = ({1'b0, b} + {64'b0, bi}) > {1'b0, a};
        af = ({1'b0, b[3:0]} + {4'b0, bi}) > {1'b0, a[3:0]};
        sres = sx(a, n) - sx(b, n) - $signed({67'b0, bi});
        of = (sres > smax) || (sres < smin);
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      default: r = b;
    endcase
    zf = (r == 64'd0);
    sf = r[n-1];
    ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(r[k]);
    pf = (ones % 2) == 0;
    if (sz == 2 || sz == 3) full = r;
    else full = (old_v & ~m) | r;
    if (op == 7) begin
      exp_d  = cnd ? full : old_v;
      exp_cc = cc_in;
    end else begin
      exp_d = full;
      fl = '0;
      fl[0] = c; fl[2] = pf; fl[4] = af; fl[6] = zf; fl[7] = sf; fl[11] = of;
      wr = msk & 16'b0000_1000_1101_0101;
      exp_cc = (cc_in & ~wr) | (fl & wr);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] lcg;
    logic [63:0] ed;
    logic [15:0] ec;
    lcg = 64'h0DDB_1A5E_5BAD_5EED;
    // R12: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset dest", dest_o, 64'h0);
    check("R12 reset cc", {48'h0, cc_o}, 64'h0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 8; op++) begin
        for (int i = 0; i < 13; i++) begin
          for (int j = 0; j < 13; j++) begin
            for (int cf = 0; cf < 2; cf++) begin
              logic [63:0] b_val;
              string dtag, ctag;
              lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
              op_i        = 3'(op);
              size_i      = 2'(sz);
              src1_i      = pat(i);
              use_imm_i   = ((i + j) % 2) == 1;
              imm_i       = pat(j)[7:0] ^ 8'(i);
              src2_i      = use_imm_i ? ~pat(j) : pat(j);
              b_val       = use_imm_i ? {56'h0, imm_i} : src2_i;
              cond_i      = lcg[60];
              flag_mask_i = (j % 3 == 0) ? 16'hFFFF : lcg[15:0];
              cc_i        = {lcg[47:33], cf[0]};
              dest_old_i  = lcg ^ {lcg[31:0], lcg[63:32]};
              model(op, sz, src1_i, b_val, cf[0], cond_i, dest_old_i,
                    flag_mask_i, cc_i, ed, ec);
              case (op)
                0, 1: begin dtag = "R1 R7"; ctag = "R3 R8 R9 R10"; end
                2, 3: begin dtag = "R2 R7"; ctag = "R3 R8 R9 R10"; end
                4, 5, 6: begin dtag = "R5 R7"; ctag = "R3 R5 R9"; end
                default: begin dtag = "R6 R7"; ctag = "R11"; end
              endcase
              if (use_imm_i) dtag = {dtag, " R4"};
              @(posedge clk);
              #1;
              check($sformatf("%s dest op=%0d sz=%0d a=%0d b=%0d", dtag, op, sz, i, j),
                    dest_o, ed);
              check($sformatf("%s cc op=%0d sz=%0d a=%0d b=%0d", ctag, op, sz, i, j),
                    {48'h0, cc_o}, {48'h0, ec});
            end
          end
        end
      end
    end
    // R12: reset clears outputs again after activity
    rst_n = 1'b0;
    #1;
    check("R12 reset again dest", dest_o, 64'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule